// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block produces the low-order word address for a short memory burst. On a cycle where any of its active-low address strobes is asserted, it captures the low bits of the external address as the burst start. It also captures the upper bits, which it then passes through unchanged. It clears its internal beat count at the same time. On each later cycle with the active-low advance input asserted, the beat count steps once. The beat count wraps after the last beat of the burst.

A mode selection chooses how the beat count maps to the output address. Sequential order adds the count to the start and wraps around. Interleaved order XORs the count into the start. The mode comes from a pin by default. A parameter can disconnect the pin and fix the order to a default value, which models a mode input left floating. A flag marks the final beat of the burst.

With the default parameters the burst is four beats long, using two low address bits. All state is held in registers that update on the rising clock edge. The outputs are decoded from that state, so a load or an advance shows up on the outputs right after the edge that accepts it.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset sets the whole output address to zero and the beat count to 0, so `last_beat` is low.
- R2: On a clock edge where any bit of `strb_n` is low, the start address is loaded from `ext_addr[BEAT_W-1:0]` and the beat count is cleared. The low output bits then equal the loaded value.
- R3: When a load and an advance (`adv_n` low) occur in the same cycle, the load wins and the beat count is 0 afterwards.
- R4: With `mode_il` low (pin in use), the low output bits are (start + beat count) modulo 2**BEAT_W. Starting at 01, this gives 01, 10, 11, 00.
- R5: With `mode_il` high, the low output bits are start XOR beat count. Starting at 01, this gives 01, 00, 11, 10.
- R6: After 2**BEAT_W advances from a load, the low output bits are back at the start address.
- R7: On a cycle with no strobe and `adv_n` high, the whole output address holds its value.
- R8: `last_beat` is high exactly when the beat count equals 2**BEAT_W-1, which is the fourth beat for the default width.
- R9: With USE_MODE_PIN=0, `mode_il` has no effect and the order is set by DEFAULT_IL (1 = interleaved).
- R10: The upper output bits `burst_addr[AW-1:BEAT_W]` equal `ext_addr[AW-1:BEAT_W]` from the last load. Cycles without a load leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strb_n | input | NSTRB | Address strobes, active low; any low bit loads |
| adv_n | input | 1 | Advance, active low |
| mode_il | input | 1 | Order select: 0 sequential, 1 interleaved |
| ext_addr | input | AW | External address |
| burst_addr | output | AW | Upper bits as loaded, low bits burst address |
| last_beat | output | 1 | High on the final beat of the burst |

## Verification
Every result is due one clock edge after its stimulus. That holds for a load, an advance, a hold and a reset. The only path with no register on it is from a change of `mode_il` to the mapped address, but the mode stays static within each burst. The bench therefore drives inputs on the falling edge and checks the outputs at the next falling edge, after exactly one rising edge has taken effect. In the sweep, the bench changes `ext_addr` after every load. A later stray capture would then show up as a wrong upper or low field.

// File: rtl/burst_agen_pkg.sv
package burst_agen_pkg;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_XOR = 1'b1
   } order_e;

   function automatic order_e pick_order(input logic use_pin, input logic pin_v, input logic dflt);
      if (use_pin) return order_e'(pin_v);
      return order_e'(dflt);
   endfunction

endpackage

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              adv_n,
   input  logic [BEAT_W-1:0] start_in,
   output logic [BEAT_W-1:0] start_q,
   output logic [BEAT_W-1:0] beat_q,
   output logic              last
);

   localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         start_q <= '0;
         beat_q  <= '0;
      end else if (load) begin
         start_q <= start_in;
         beat_q  <= '0;
      end else if (!adv_n) begin
         beat_q  <= beat_q + BEAT_ONE;
      end
   end

   assign last = &beat_q;

endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
   import burst_agen_pkg::*;
#(
   parameter int BEAT_W       = 2,
   parameter bit USE_MODE_PIN = 1'b1,
   parameter bit DEFAULT_IL   = 1'b0
) (
   input  logic              mode_il,
   input  logic [BEAT_W-1:0] start,
   input  logic [BEAT_W-1:0] beat,
   output logic              il_eff,
   output logic [BEAT_W-1:0] low_addr
);

   generate
      if (USE_MODE_PIN) begin : g_pin
         order_e ord;
         logic [BEAT_W-1:0] seq_v;
         logic [BEAT_W-1:0] xor_v;
         always_comb begin
            ord   = pick_order(1'b1, mode_il, DEFAULT_IL);
            seq_v = start + beat;
            xor_v = start ^ beat;
            low_addr = (ord == ORD_XOR) ? xor_v : seq_v;
         end
         assign il_eff = (ord == ORD_XOR);
      end else if (DEFAULT_IL) begin : g_fix_xor
         logic unused_pin;
         assign unused_pin = mode_il;
         assign low_addr   = start ^ beat;
         assign il_eff     = 1'b1;
      end else begin : g_fix_seq
         logic unused_pin;
         assign unused_pin = mode_il;
         assign low_addr   = start + beat;
         assign il_eff     = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bag_upper_reg.sv
module bag_upper_reg #(
   parameter int UW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [UW-1:0] d,
   output logic [UW-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int AW           = 8,
   parameter int BEAT_W       = 2,
   parameter int NSTRB        = 2,
   parameter bit USE_MODE_PIN = 1'b1,
   parameter bit DEFAULT_IL   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NSTRB-1:0] strb_n,
   input  logic             adv_n,
   input  logic             mode_il,
   input  logic [AW-1:0]    ext_addr,
   output logic [AW-1:0]    burst_addr,
   output logic             last_beat
);

   localparam int UW = AW - BEAT_W;

   generate
      if (BEAT_W < 1)   begin : g_bad_bw  $error("BEAT_W must be at least 1");      end
      if (AW <= BEAT_W) begin : g_bad_aw  $error("AW must exceed BEAT_W");          end
      if (NSTRB < 1)    begin : g_bad_ns  $error("NSTRB must be at least 1");       end
   endgenerate

   logic              load;
   logic [BEAT_W-1:0] start_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] low_addr;
   logic [UW-1:0]     upper_q;
   logic              il_eff;

   assign load = ~&strb_n;

   bag_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .adv_n    (adv_n),
      .start_in (ext_addr[BEAT_W-1:0]),
      .start_q  (start_q),
      .beat_q   (beat_q),
      .last     (last_beat)
   );

   bag_order_map #(
      .BEAT_W       (BEAT_W),
      .USE_MODE_PIN (USE_MODE_PIN),
      .DEFAULT_IL   (DEFAULT_IL)
   ) u_map (
      .mode_il  (mode_il),
      .start    (start_q),
      .beat     (beat_q),
      .il_eff   (il_eff),
      .low_addr (low_addr)
   );

   bag_upper_reg #(.UW(UW)) u_up (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .d    (ext_addr[AW-1:BEAT_W]),
      .q    (upper_q)
   );

   assign burst_addr = {upper_q, low_addr};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int AW     = 8,
   parameter int BEAT_W = 2,
   parameter int NSTRB  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic [NSTRB-1:0]  strb_n,
   input logic              adv_n,
   input logic [AW-1:0]     ext_addr,
   input logic [AW-1:0]     burst_addr,
   input logic              last_beat,
   input logic              il_eff,
   input logic [BEAT_W-1:0] start_q,
   input logic [BEAT_W-1:0] beat_q
);

   logic ld;
   assign ld = ~&strb_n;

   // R1
   a_r1_reset_zero: assert property (@(posedge clk)
      rst |=> (burst_addr == '0 && !last_beat));

   // R2 and R10
   a_r2_load_start: assert property (@(posedge clk) disable iff (rst)
      ld |=> (burst_addr[BEAT_W-1:0] == $past(ext_addr[BEAT_W-1:0])));
   a_r10_upper_load: assert property (@(posedge clk) disable iff (rst)
      ld |=> (burst_addr[AW-1:BEAT_W] == $past(ext_addr[AW-1:BEAT_W])));

   // R3
   a_r3_load_wins: assert property (@(posedge clk) disable iff (rst)
      (ld && !adv_n) |=> (beat_q == '0 && !last_beat));

   // R4
   a_r4_seq_step: assert property (@(posedge clk) disable iff (rst)
      (!ld && !adv_n) |=> (il_eff || $past(il_eff) ||
         burst_addr[BEAT_W-1:0] == $past(burst_addr[BEAT_W-1:0]) + BEAT_W'(1)));

   // R5
   a_r5_xor_step: assert property (@(posedge clk) disable iff (rst)
      (!ld && !adv_n) |=> (!il_eff || !$past(il_eff) ||
         (burst_addr[BEAT_W-1:0] ^ $past(burst_addr[BEAT_W-1:0])) == (beat_q ^ $past(beat_q))));

   // R6
   a_r6_wrap_home: assert property (@(posedge clk) disable iff (rst)
      (!ld && !adv_n && last_beat) |=> (burst_addr[BEAT_W-1:0] == start_q && $stable(start_q)));

   // R7
   a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      (!ld && adv_n) |=> ($stable(burst_addr[AW-1:BEAT_W]) && $stable(beat_q)));

   // R8
   a_r8_last_after_steps: assert property (@(posedge clk) disable iff (rst)
      (!ld && !adv_n && last_beat) |=> !last_beat);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
   .AW     (AW),
   .BEAT_W (BEAT_W),
   .NSTRB  (NSTRB)
) i_chk (
   .clk        (clk),
   .rst        (rst),
   .strb_n     (strb_n),
   .adv_n      (adv_n),
   .ext_addr   (ext_addr),
   .burst_addr (burst_addr),
   .last_beat  (last_beat),
   .il_eff     (il_eff),
   .start_q    (start_q),
   .beat_q     (beat_q)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;

   localparam int AW = 8;
   localparam int BW = 2;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    strb_n = 2'b11;
   logic          adv_n = 1'b1;
   logic          mode_il = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic [AW-1:0] burst_addr, burst_addr_fix;
   logic          last_beat, last_beat_fix;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   burst_addr_gen #(.AW(AW), .BEAT_W(BW), .NSTRB(2)) i_burst_addr_gen (
      .clk(clk), .rst(rst), .strb_n(strb_n), .adv_n(adv_n), .mode_il(mode_il),
      .ext_addr(ext_addr), .burst_addr(burst_addr), .last_beat(last_beat));

   burst_addr_gen #(.AW(AW), .BEAT_W(BW), .NSTRB(2), .USE_MODE_PIN(1'b0), .DEFAULT_IL(1'b1))
   i_burst_addr_gen_fix (
      .clk(clk), .rst(rst), .strb_n(strb_n), .adv_n(adv_n), .mode_il(mode_il),
      .ext_addr(ext_addr), .burst_addr(burst_addr_fix), .last_beat(last_beat_fix));

   task automatic chk(input string req, input int got, input int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int exp_low(input int m, input int s, input int k);
      if (m == 1) return (s ^ k) & (NB - 1);
      return (s + k) % NB;
   endfunction

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got 0 expected 1 (run completion)");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int up;
      @(negedge clk);
      step();
      step();
      // R1: reset state
      chk("R1 addr", burst_addr, 0);
      chk("R1 last", last_beat, 0);
      rst = 1'b0;
      step();
      chk("R7 idle hold after reset", burst_addr, 0);

      for (int m = 0; m < 2; m++) begin
         mode_il = m[0];
         for (int s = 0; s < NB; s++) begin
            for (int sel = 0; sel < 3; sel++) begin
               up = (m * 37 + s * 11 + sel * 5 + 3) & 63;
               ext_addr = AW'((up << BW) | s);
               strb_n = (sel == 0) ? 2'b10 : (sel == 1) ? 2'b01 : 2'b00;
               adv_n = 1'b1;
               step();
               chk("R2 load low", burst_addr[BW-1:0], s);
               chk("R10 upper load", burst_addr[AW-1:BW], up);
               chk("R8 last clear on load", last_beat, 0);
               chk("R9 fixed load", burst_addr_fix[BW-1:0], s);
               strb_n = 2'b11;
               ext_addr = ~ext_addr;
               for (int k = 1; k <= NB + 1; k++) begin
                  adv_n = 1'b0;
                  step();
                  if (m == 0) chk("R4 sequential", burst_addr[BW-1:0], exp_low(0, s, k));
                  else        chk("R5 interleaved", burst_addr[BW-1:0], exp_low(1, s, k));
                  if (k == NB) chk("R6 wrap home", burst_addr[BW-1:0], s);
                  chk("R8 last flag", last_beat, ((k % NB) == NB - 1) ? 1 : 0);
                  chk("R9 fixed order", burst_addr_fix[BW-1:0], exp_low(1, s, k));
                  chk("R10 upper kept", burst_addr[AW-1:BW], up);
                  if (k % 2 == 1) begin
                     adv_n = 1'b1;
                     step();
                     chk("R7 hold", burst_addr[BW-1:0], exp_low(m, s, k));
                     chk("R7 hold upper", burst_addr[AW-1:BW], up);
                  end
               end
               // R3: load with advance in the same cycle, mid burst
               adv_n = 1'b0;
               step();
               up = (up + 17) & 63;
               ext_addr = AW'((up << BW) | ((s + 2) % NB));
               strb_n = 2'b10;
               adv_n = 1'b0;
               step();
               chk("R3 load priority", burst_addr[BW-1:0], (s + 2) % NB);
               chk("R3 last low", last_beat, 0);
               strb_n = 2'b11;
               step();
               chk("R3 step after load", burst_addr[BW-1:0], exp_low(m, (s + 2) % NB, 1));
               adv_n = 1'b1;
            end
         end
      end

      // R1 again mid burst
      rst = 1'b1;
      step();
      chk("R1 reset mid burst", burst_addr, 0);
      rst = 1'b0;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule